// File: doc/BRIEF.md
# Serial panel phase sequencer

This block runs transactions on a serial display link derived from SPI. The link has a clock (`sclk`), an active-low chip select (`csn`), a data/command line (`dcx`) and up to four bidirectional data lanes. Each transaction passes through up to four phases in a fixed order: command, address, dummy, then data. Every phase has its own length and its own lane count (1, 2 or 4 lanes). A phase with zero length is skipped.

In a write transaction the block serializes every phase onto the lanes. The bytes for command, address and data come from a valid/ready input stream. The dummy bytes are zeros that the block generates itself. In a read transaction the command and address bytes still come from the input stream. The dummy gap is then a number of `sclk` cycles with the lanes released, and the data bytes are sampled from `sd_in` and delivered on a valid/ready output stream.

Back-pressure on both streams stops the serial clock. A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both high, and `sclk` stays low while the block waits for it. A received byte stays on `rx_data` with `rx_valid` high until `rx_ready` is seen. No `sclk` edge occurs during that wait. The source must hold `tx_data` steady while `tx_valid` is high and not yet accepted.

Top module: `serial_panel_seq`

## Requirements
- R1: After reset and while idle: `csn`=1, `sclk`=0, `dcx`=1, `sd_oe`=0, `busy`=0, `tx_ready`=0, `rx_valid`=0.
- R2: Phases run in the order command, address, dummy, data. A phase of length zero produces no `sclk` cycles, and a transaction with all lengths zero produces none at all.
- R3: `dcx` is 0 at every rising `sclk` edge of the command phase and 1 at every rising edge of the other phases.
- R4: Lane code 0 means 1 lane (`sd_out[0]`), code 1 means 2 lanes (`sd_out[1:0]`) and code 2 means 4 lanes (`sd_out[3:0]`). The higher-numbered lane carries the more significant bit, bits go out most-significant first, a byte takes 8/lanes `sclk` cycles, and `sd_oe` equals the lane mask while a phase drives.
- R5: `sd_out` changes only while `sclk` is low, that is, at a falling edge or between bytes. `sd_in` is sampled at the rising edge, using the same lane mapping as R4.
- R6: A write transaction's dummy phase sends `dmy_len` zero bytes on the dummy lanes and takes nothing from the input stream.
- R7: In a read transaction the dummy phase lasts `dmy_len` `sclk` cycles and the data phase lasts `data_len` bytes. In both phases `sd_oe`=0, and each assembled data byte appears on `rx_data`.
- R8: A byte is consumed only when `tx_valid` and `tx_ready` are both high. While the block waits for one, `sclk` stays low, and exactly the command, address and (for writes) data bytes are consumed.
- R9: `rx_valid` stays high with `rx_data` stable until `rx_ready` is high. No `sclk` edge happens during that wait.
- R10: `csn` falls at least one clock before the first rising `sclk` edge. It rises one clock after the last falling edge, and in that same cycle `done` is high for exactly one clock.
- R11: `start` is ignored while `busy` is 1. It neither restarts the transaction nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one `sclk` half-period per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction; configuration is captured on this cycle |
| rx_mode | input | 1 | 0 = write transaction, 1 = read transaction |
| cmd_len | input | LEN_W | Command phase length in bytes |
| cmd_lanes | input | 2 | Command lane code |
| addr_len | input | LEN_W | Address phase length in bytes |
| addr_lanes | input | 2 | Address lane code |
| dmy_len | input | LEN_W | Dummy length: bytes for writes, `sclk` cycles for reads |
| dmy_lanes | input | 2 | Dummy lane code (writes only) |
| data_len | input | LEN_W | Data phase length in bytes |
| data_lanes | input | 2 | Data lane code |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse when `csn` is released |
| tx_valid | input | 1 | Input stream byte valid |
| tx_ready | output | 1 | Block accepts an input byte |
| tx_data | input | 8 | Input stream byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Sink accepts the received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock, idles low |
| csn | output | 1 | Chip select, active low |
| dcx | output | 1 | 0 = command, 1 = address, dummy or data |
| sd_out | output | 4 | Lane output values |
| sd_oe | output | 4 | Lane output enables |
| sd_in | input | 4 | Lane input values |

## Verification
An internal fault shows up at the lanes within one byte time. A wrong phase register or byte count shows as a bad `dcx` level at a rising edge, a byte with the wrong value, or a wrong total number of `sclk` rising edges, visible by the end of the transaction. A slice counter or shift fault corrupts the very byte in which it occurs, because each byte is rebuilt independently from the lane values captured at each rising edge. A fault in the termination logic shows within one clock, as a `done` pulse that is missing or doubled, or as `csn` still low when `done` fires.

// File: rtl/spl_pkg.sv
`timescale 1ns/1ps
package spl_pkg;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_DMY = 2'd2, PH_DATA = 2'd3} phase_e;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_LOAD, ST_SHIFT, ST_HOLD, ST_TAIL} state_e;

  // Lane enable mask for a lane code
  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // sclk cycles per byte for a lane code
  function automatic logic [3:0] slices(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd8;
      2'd1:    return 4'd4;
      default: return 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/spl_phase_pick.sv
`timescale 1ns/1ps
module spl_phase_pick
  import spl_pkg::*;
(
  input  logic [3:0] nz,
  input  logic       from_start,
  input  phase_e     cur,
  output logic       found,
  output phase_e     nxt
);
  // Lowest non-empty phase after cur (or from the first phase)
  always_comb begin
    found = 1'b0;
    nxt   = PH_DATA;
    for (int i = 3; i >= 0; i--) begin
      if (nz[i] && (from_start || i > int'(cur))) begin
        found = 1'b1;
        nxt   = phase_e'(2'(i));
      end
    end
  end
endmodule

// File: rtl/spl_lane_shift.sv
`timescale 1ns/1ps
module spl_lane_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  input  logic       fill_en,
  input  logic [1:0] lanes,
  input  logic [3:0] sd_in,
  output logic [7:0] sh_o,
  output logic [3:0] out_o
);
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load) begin
      sh <= load_val;
    end else if (step) begin
      case (lanes)
        2'd0:    sh <= {sh[6:0], fill_en & sd_in[0]};
        2'd1:    sh <= {sh[5:0], fill_en ? sd_in[1:0] : 2'b00};
        default: sh <= {sh[3:0], fill_en ? sd_in : 4'b0000};
      endcase
    end
  end

  always_comb begin
    case (lanes)
      2'd0:    out_o = {3'b000, sh[7]};
      2'd1:    out_o = {2'b00, sh[7:6]};
      default: out_o = sh[7:4];
    endcase
  end

  assign sh_o = sh;

  // R4
  load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(load && step));
endmodule

// File: rtl/serial_panel_seq.sv
`timescale 1ns/1ps
module serial_panel_seq
  import spl_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_mode,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [1:0]       cmd_lanes,
  input  logic [LEN_W-1:0] addr_len,
  input  logic [1:0]       addr_lanes,
  input  logic [LEN_W-1:0] dmy_len,
  input  logic [1:0]       dmy_lanes,
  input  logic [LEN_W-1:0] data_len,
  input  logic [1:0]       data_lanes,
  output logic             busy,
  output logic             done,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             sclk,
  output logic             csn,
  output logic             dcx,
  output logic [3:0]       sd_out,
  output logic [3:0]       sd_oe,
  input  logic [3:0]       sd_in
);
  localparam int NPH = 4;

  state_e                      state;
  phase_e                      phase;
  logic                        rx_q;
  logic [NPH-1:0][LEN_W-1:0]   len_q;
  logic [NPH-1:0][1:0]         lanes_q;
  logic [LEN_W-1:0]            cnt;
  logic [3:0]                  sl;
  logic                        sclk_q, csn_q, done_q;

  logic [LEN_W-1:0] cur_len;
  logic [1:0]       cur_lanes;
  logic             rx_dmy, rx_dat, drive, need_tx, active;
  logic [3:0]       spu;
  logic             last_slice, last_unit;
  logic [NPH-1:0]   nz;
  logic             found;
  phase_e           nxt;
  state_e           adv_state;
  phase_e           adv_phase;
  logic [LEN_W-1:0] adv_cnt;
  logic             ld, step;
  logic [7:0]       sh;
  logic [3:0]       lane_out;

  for (genvar g = 0; g < NPH; g++) begin : g_nz
    assign nz[g] = |len_q[g];
  end

  assign cur_len    = len_q[phase];
  assign cur_lanes  = lanes_q[phase];
  assign rx_dmy     = rx_q && (phase == PH_DMY);
  assign rx_dat     = rx_q && (phase == PH_DATA);
  assign drive      = !(rx_dmy || rx_dat);
  assign need_tx    = drive && (phase != PH_DMY);
  assign active     = (state == ST_LOAD) || (state == ST_SHIFT) || (state == ST_HOLD);
  assign spu        = rx_dmy ? 4'd1 : slices(cur_lanes);
  assign last_slice = (sl == spu - 4'd1);
  assign last_unit  = (cnt == cur_len - LEN_W'(1));

  spl_phase_pick pick_i (
    .nz         (nz),
    .from_start (state == ST_SETUP),
    .cur        (phase),
    .found      (found),
    .nxt        (nxt)
  );

  // Where to go after a finished byte (or dummy cycle)
  always_comb begin
    adv_state = ST_LOAD;
    adv_phase = phase;
    adv_cnt   = cnt + LEN_W'(1);
    if (last_unit) begin
      if (found) begin
        adv_phase = nxt;
        adv_cnt   = '0;
      end else begin
        adv_state = ST_TAIL;
      end
    end
  end

  assign ld   = (state == ST_LOAD) && (!need_tx || tx_valid);
  assign step = (state == ST_SHIFT) &&
                ((!sclk_q && rx_dat) || (sclk_q && !last_slice && !rx_dat));

  spl_lane_shift shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (need_tx ? tx_data : 8'h00),
    .step     (step),
    .fill_en  (rx_dat),
    .lanes    (cur_lanes),
    .sd_in    (sd_in),
    .sh_o     (sh),
    .out_o    (lane_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_CMD;
      rx_q    <= 1'b0;
      len_q   <= '0;
      lanes_q <= '0;
      cnt     <= '0;
      sl      <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          rx_q    <= rx_mode;
          len_q   <= {data_len, dmy_len, addr_len, cmd_len};
          lanes_q <= {data_lanes, dmy_lanes, addr_lanes, cmd_lanes};
          csn_q   <= 1'b0;
          state   <= ST_SETUP;
        end
        ST_SETUP: begin
          if (found) begin
            phase <= nxt;
            cnt   <= '0;
            state <= ST_LOAD;
          end else begin
            state <= ST_TAIL;
          end
        end
        ST_LOAD: if (!need_tx || tx_valid) begin
          sl    <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (!last_slice) begin
              sl <= sl + 4'd1;
            end else if (rx_dat) begin
              state <= ST_HOLD;
            end else begin
              state <= adv_state;
              phase <= adv_phase;
              cnt   <= adv_cnt;
            end
          end
        end
        ST_HOLD: if (rx_ready) begin
          state <= adv_state;
          phase <= adv_phase;
          cnt   <= adv_cnt;
        end
        ST_TAIL: begin
          csn_q  <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign tx_ready = (state == ST_LOAD) && need_tx;
  assign rx_valid = (state == ST_HOLD);
  assign rx_data  = sh;
  assign sclk     = sclk_q;
  assign csn      = csn_q;
  assign dcx      = !(active && (phase == PH_CMD));
  assign sd_oe    = (active && drive) ? lane_mask(cur_lanes) : 4'b0000;
  assign sd_out   = lane_out & sd_oe;

  // R10
  csn_gates_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n) csn |-> !sclk);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_with_csn_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> csn);
  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && !sclk);
  // R5
  out_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(sd_out));
  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) csn |-> (sd_oe == 4'b0000));
  // R3
  dcx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) !dcx |-> !csn);
  // R4
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe == 4'b0000) || (sd_oe == 4'b0001) || (sd_oe == 4'b0011) || (sd_oe == 4'b1111));
  // R8
  tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !tx_valid |=> !sclk);
endmodule

// File: tb/serial_panel_seq_tb_top.sv
`timescale 1ns/1ps
module serial_panel_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 0, rx_mode = 0;
  logic [7:0] cmd_len = 0, addr_len = 0, dmy_len = 0, data_len = 0;
  logic [1:0] cmd_lanes = 0, addr_lanes = 0, dmy_lanes = 0, data_lanes = 0;
  logic       busy, done, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic       sclk, csn, dcx;
  logic [3:0] sd_out, sd_oe, sd_in;

  int nchk = 0, nfail = 0;
  int nr = 0;
  logic [3:0] r_out [0:255];
  logic [3:0] r_oe  [0:255];
  logic       r_dcx [0:255];
  logic       r_csn [0:255];
  logic [7:0] txq [0:63];
  logic [7:0] rxq [0:63];
  int txn = 0, txi = 0, rxn = 0, dcount = 0, csn_bad = 0;
  bit txgap = 0, rxgap = 0, acc = 0;
  int tcyc = 0, rcyc = 0;
  int plen [4];
  int pcode [4];
  bit prx;

  function automatic logic [3:0] pat(input int n);
    return 4'((n * 7 + 5) % 16);
  endfunction
  function automatic int lanes_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction
  function automatic logic [3:0] mask_of(input int l);
    return (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : 4'b1111;
  endfunction

  assign sd_in = pat(nr);

  serial_panel_seq #(.LEN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode),
    .cmd_len(cmd_len), .cmd_lanes(cmd_lanes), .addr_len(addr_len), .addr_lanes(addr_lanes),
    .dmy_len(dmy_len), .dmy_lanes(dmy_lanes), .data_len(data_len), .data_lanes(data_lanes),
    .busy(busy), .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .csn(csn), .dcx(dcx), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  // Rising-edge monitor (slave side)
  always @(posedge sclk) begin
    if (nr < 256) begin
      r_out[nr] = sd_out; r_oe[nr] = sd_oe; r_dcx[nr] = dcx; r_csn[nr] = csn;
    end
    nr = nr + 1;
  end

  always @(negedge clk) begin
    if (done) begin
      dcount = dcount + 1;
      if (!csn) csn_bad = csn_bad + 1;
    end
  end

  // Input stream source
  initial begin
    tx_valid = 0; tx_data = 0;
    forever begin
      @(negedge clk);
      tcyc = tcyc + 1;
      if (acc) begin tx_valid = 0; acc = 0; end
      if (!tx_valid && txi < txn && (!txgap || tcyc % 3 == 0)) begin
        tx_valid = 1; tx_data = txq[txi];
      end
      #1;
      if (tx_valid && tx_ready) begin acc = 1; txi = txi + 1; end
    end
  end

  // Output stream sink
  initial begin
    rx_ready = 0;
    forever begin
      @(negedge clk);
      rcyc = rcyc + 1;
      rx_ready = !rxgap || (rcyc % 3 == 0);
      #1;
      if (rx_valid && rx_ready && rxn < 64) begin rxq[rxn] = rx_data; rxn = rxn + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input bit rx, input int cl, input int cc, input int al, input int ac,
                        input int dl, input int dc, input int tl, input int tc,
                        input bit tg, input bit rg);
    int nb;
    @(negedge clk); #2;
    prx = rx;
    plen[0] = cl; plen[1] = al; plen[2] = dl; plen[3] = tl;
    pcode[0] = cc; pcode[1] = ac; pcode[2] = dc; pcode[3] = tc;
    nb = cl + al + (rx ? 0 : tl);
    for (int i = 0; i < nb; i++) txq[i] = 8'((i * 37 + 11 + cl * 5 + tl) % 256);
    txgap = tg; rxgap = rg;
    txi = 0; txn = nb; rxn = 0; nr = 0; dcount = 0; csn_bad = 0;
    @(negedge clk);
    rx_mode = rx;
    cmd_len = 8'(cl); cmd_lanes = 2'(cc); addr_len = 8'(al); addr_lanes = 2'(ac);
    dmy_len = 8'(dl); dmy_lanes = 2'(dc); data_len = 8'(tl); data_lanes = 2'(tc);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (dcount == 0 && t < 3000) begin @(negedge clk); t++; end
    chk(dcount != 0, "R10 done timeout", t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_xfer(input string tag);
    int p = 0, b = 0, l, spu;
    logic [7:0] got, exp;
    bit csn_ok = 1;
    for (int ph = 0; ph < 4; ph++) begin
      l = lanes_of(pcode[ph]);
      spu = 8 / l;
      if (prx && ph == 2) begin
        for (int k = 0; k < plen[2]; k++) begin
          chk(r_oe[p] == 4'b0000, {"R7 rx dummy released ", tag}, int'(r_oe[p]), 0);
          p++;
        end
      end else begin
        for (int j = 0; j < plen[ph]; j++) begin
          got = 0; exp = 0;
          for (int k = 0; k < spu; k++) begin
            got = 8'((got << l) | (r_out[p + k] & mask_of(l)));
            exp = 8'((exp << l) | (pat(p + k) & mask_of(l)));
          end
          if (prx && ph == 3) begin
            chk(j < rxn && rxq[j] == exp, {"R7 rx byte ", tag}, int'(rxq[j]), int'(exp));
            chk(r_oe[p] == 4'b0000, {"R7 rx data released ", tag}, int'(r_oe[p]), 0);
          end else begin
            exp = (ph == 2) ? 8'h00 : txq[b];
            if (ph != 2) b++;
            chk(got == exp, (ph == 2) ? {"R6 tx dummy byte ", tag} : {"R4 tx byte ", tag},
                int'(got), int'(exp));
            chk(r_oe[p] == mask_of(l), {"R4 lane enables ", tag}, int'(r_oe[p]), int'(mask_of(l)));
            chk(r_dcx[p] == (ph != 0), {"R3 dcx level ", tag}, int'(r_dcx[p]), int'(ph != 0));
          end
          p += spu;
        end
      end
    end
    for (int i = 0; i < p && i < 256; i++) if (r_csn[i]) csn_ok = 0;
    chk(nr == p, {"R2 sclk rising edges ", tag}, nr, p);
    chk(csn_ok, {"R10 csn low at every edge ", tag}, 0, 1);
    chk(txi == txn, {"R8 bytes consumed ", tag}, txi, txn);
    chk(dcount == 1 && csn_bad == 0, {"R10 single done with csn high ", tag}, dcount, 1);
    chk(rxn == (prx ? plen[3] : 0), {"R9 rx bytes delivered ", tag}, rxn, prx ? plen[3] : 0);
    chk(!busy && csn && !sclk, {"R1 idle after ", tag}, {busy, csn, sclk}, 3'b010);
  endtask

  task automatic t_reset();
    chk(csn == 1 && sclk == 0 && dcx == 1, "R1 reset lines", {csn, sclk, dcx}, 3'b101);
    chk(sd_oe == 0 && busy == 0, "R1 reset oe/busy", {sd_oe, busy}, 0);
    chk(tx_ready == 0 && rx_valid == 0, "R1 reset streams", {tx_ready, rx_valid}, 0);
  endtask

  task automatic t_tx_full();
    launch(0, 1, 0, 3, 2, 1, 1, 4, 2, 0, 0);
    wait_done();
    check_xfer("tx_full");
  endtask

  task automatic t_tx_skip_stall();
    launch(0, 2, 1, 0, 2, 0, 2, 3, 0, 1, 0);
    wait_done();
    check_xfer("tx_skip_stall R8");
  endtask

  task automatic t_rx();
    launch(1, 1, 0, 2, 1, 5, 0, 3, 2, 0, 1);
    wait_done();
    check_xfer("rx R9");
  endtask

  task automatic t_busy_start();
    launch(1, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0);
    repeat (6) @(negedge clk);
    data_len = 8'd1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(dcount == 1 && !busy, "R11 start ignored while busy", dcount, 1);
    check_xfer("busy_start R11");
  endtask

  task automatic t_all_zero();
    launch(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wait_done();
    chk(nr == 0, "R2 empty transaction edges", nr, 0);
    chk(dcount == 1, "R10 empty transaction done", dcount, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail = nfail + 1;
    $display("FAIL R10 watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_full();
    t_tx_skip_stall();
    t_rx();
    t_busy_start();
    t_all_zero();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule